// File: doc/BRIEF.md
# Page Permission Fault Checker

This block sits after a page-table walker and rules on whether a memory access may proceed. It is given the flag bits of the leaf entry the walker returned, a flag saying whether an entry was found, the kind of access (instruction fetch, load or store), the hart's current privilege level, and the two status controls. The first control lets loads read pages marked execute-only. The second lets supervisor code touch pages owned by user mode. From these it decides whether the access raises a page fault, picks the exception cause, and returns the faulting virtual address as the trap value.

All of this is one level of logic followed by a single register stage. A result appears on the cycle after a valid strobe, so the walker can offer a new request on every cycle. When there is no fault, the cause and trap value outputs stay at zero.

Top module: `pg_perm_check`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, valid_o and fault_o are 0 and cause_o and tval_o are 0.
- R2: valid_o is 1 on exactly the cycle after a cycle in which valid_i is 1, and 0 otherwise; fault_o is never 1 while valid_o is 0.
- R3: When pte_found_i is 0, the access faults whatever the flag bits hold, with the cause of its own access type.
- R4: When the valid flag (entry bit 0) is 0, the access faults.
- R5: The access faults when the entry lacks the permission its type needs: read (bit 1) for a load, write (bit 2) for a store, execute (bit 3) for a fetch.
- R6: With mxr_i = 0, a load passes the permission test only if the read bit is set. With mxr_i = 1, it passes if the read bit or the execute bit is set. mxr_i has no effect on stores or fetches.
- R7: When priv_i is supervisor (code 1) and sum_i is 0, any access to an entry whose user bit (bit 4) is set faults. In user mode (code 0) and machine mode (code 3) the user bit causes no fault.
- R8: The access code is 0 for fetch, 1 for load and 2 for store; code 3 is handled as a load. On a fault, cause_o is 12 for a fetch, 13 for a load and 15 for a store.
- R9: On a fault, tval_o equals the vaddr_i that was presented with the strobe.
- R10: When valid_o is 1 and fault_o is 0, cause_o and tval_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| vaddr_i | input | VA_W | Virtual address of the access |
| pte_flags_i | input | 5 | Leaf entry flags: bit 0 valid, 1 read, 2 write, 3 execute, 4 user |
| pte_found_i | input | 1 | The walk returned an entry |
| access_i | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| priv_i | input | 2 | 0 user, 1 supervisor, 3 machine |
| mxr_i | input | 1 | Allow loads from execute-only pages |
| sum_i | input | 1 | Allow supervisor access to user pages |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| fault_o | output | 1 | Page fault raised |
| cause_o | output | CAUSE_W | Exception cause, zero when there is no fault |
| tval_o | output | VA_W | Trap value, zero when there is no fault |

## Verification
The only state in the block is the result register. A wrong value held there appears at the ports on the very cycle after its strobe. It can show as a cause that does not match the access type, a trap value other than the presented address, non-zero side outputs on a granted access, or a result strobe that lingers into an idle cycle. A wrong decision term shows as a flipped fault_o for exactly one crafted flag, mode and control combination. Because of this, the directed cases each change one input away from a passing or a faulting baseline.

// File: rtl/pg_perm_pkg.sv
package pg_perm_pkg;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned BIT_V  = 0;
  localparam int unsigned BIT_R  = 1;
  localparam int unsigned BIT_W  = 2;
  localparam int unsigned BIT_X  = 3;
  localparam int unsigned BIT_U  = 4;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3   // handled as load
  } acc_e;

  localparam logic [1:0] PRIV_S = 2'd1;

  localparam int unsigned CAUSE_FETCH = 12;
  localparam int unsigned CAUSE_LOAD  = 13;
  localparam int unsigned CAUSE_STORE = 15;
endpackage

// File: rtl/pg_perm_eval.sv
module pg_perm_eval
  import pg_perm_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              found_i,
  input  logic [1:0]        access_i,
  input  logic [1:0]        priv_i,
  input  logic              mxr_i,
  input  logic              sum_i,
  output logic              fault_o
);
  logic perm_ok;
  logic user_block;

  always_comb begin
    case (access_i)
      ACC_FETCH: perm_ok = flags_i[BIT_X];
      ACC_STORE: perm_ok = flags_i[BIT_W];
      default:   perm_ok = flags_i[BIT_R] | (mxr_i & flags_i[BIT_X]);
    endcase
  end

  assign user_block = (priv_i == PRIV_S) & ~sum_i & flags_i[BIT_U];
  assign fault_o    = ~found_i | ~flags_i[BIT_V] | ~perm_ok | user_block;
endmodule

// File: rtl/pg_cause_map.sv
module pg_cause_map
  import pg_perm_pkg::*;
#(
  parameter int unsigned CAUSE_W = 8
) (
  input  logic [1:0]         access_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    case (access_i)
      ACC_FETCH: cause_o = CAUSE_W'(CAUSE_FETCH);
      ACC_STORE: cause_o = CAUSE_W'(CAUSE_STORE);
      default:   cause_o = CAUSE_W'(CAUSE_LOAD);
    endcase
  end
endmodule

// File: rtl/pg_result_reg.sv
module pg_result_reg #(
  parameter int unsigned CAUSE_W = 8,
  parameter int unsigned VA_W    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               fault_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [VA_W-1:0]    vaddr_i,
  output logic               valid_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [VA_W-1:0]    tval_o
);
  logic hit;
  assign hit = valid_i & fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= '0;
      tval_o  <= '0;
    end else begin
      valid_o <= valid_i;
      fault_o <= hit;
      cause_o <= hit ? cause_i : '0;
      tval_o  <= hit ? vaddr_i : '0;
    end
  end

  AST_QUIET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (cause_o == '0 && tval_o == '0)); // R10
  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> valid_o); // R2
endmodule

// File: rtl/pg_perm_check.sv
module pg_perm_check
  import pg_perm_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned CAUSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [4:0]         pte_flags_i,
  input  logic               pte_found_i,
  input  logic [1:0]         access_i,
  input  logic [1:0]         priv_i,
  input  logic               mxr_i,
  input  logic               sum_i,
  output logic               valid_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [VA_W-1:0]    tval_o
);
  logic               fault_c;
  logic [CAUSE_W-1:0] cause_c;

  pg_perm_eval u_eval (
    .flags_i (pte_flags_i),
    .found_i (pte_found_i),
    .access_i(access_i),
    .priv_i  (priv_i),
    .mxr_i   (mxr_i),
    .sum_i   (sum_i),
    .fault_o (fault_c)
  );

  pg_cause_map #(.CAUSE_W(CAUSE_W)) u_cause (
    .access_i(access_i),
    .cause_o (cause_c)
  );

  pg_result_reg #(.CAUSE_W(CAUSE_W), .VA_W(VA_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .fault_i(fault_c),
    .cause_i(cause_c),
    .vaddr_i(vaddr_i),
    .valid_o(valid_o),
    .fault_o(fault_o),
    .cause_o(cause_o),
    .tval_o (tval_o)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_MISSING_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pte_found_i) |=> fault_o); // R3
  AST_INVALID_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pte_flags_i[BIT_V]) |=> fault_o); // R4
  AST_TVAL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (!fault_o || tval_o == $past(vaddr_i))); // R9
  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cause_o == CAUSE_W'(CAUSE_FETCH) || cause_o == CAUSE_W'(CAUSE_LOAD)
                 || cause_o == CAUSE_W'(CAUSE_STORE))); // R8
endmodule

// File: tb/sim_pg_perm_check.sv
`timescale 1ns/1ps
module sim_pg_perm_check;
  localparam int VA_W = 32;
  localparam int CW   = 8;
  localparam logic [4:0] FV = 5'h01, FR = 5'h02, FW = 5'h04, FX = 5'h08, FU = 5'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [VA_W-1:0] vaddr_i = '0;
  logic [4:0] flags_i = '0;
  logic found_i = 1'b0;
  logic [1:0] acc_i = '0;
  logic [1:0] priv_i = '0;
  logic mxr_i = 1'b0;
  logic sum_i = 1'b0;
  logic valid_o, fault_o;
  logic [CW-1:0] cause_o;
  logic [VA_W-1:0] tval_o;

  int total = 0;
  int bad = 0;
  int seq = 0;

  always #5 clk = ~clk;

  pg_perm_check #(.VA_W(VA_W), .CAUSE_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .vaddr_i(vaddr_i),
    .pte_flags_i(flags_i), .pte_found_i(found_i), .access_i(acc_i),
    .priv_i(priv_i), .mxr_i(mxr_i), .sum_i(sum_i),
    .valid_o(valid_o), .fault_o(fault_o), .cause_o(cause_o), .tval_o(tval_o)
  );

  function automatic logic [CW-1:0] exp_cause(input logic [1:0] a);
    case (a)
      2'd0: return CW'(12);
      2'd2: return CW'(15);
      default: return CW'(13);
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] f, input logic fnd, input logic [1:0] a,
                       input logic [1:0] p, input logic m, input logic s,
                       input logic [VA_W-1:0] va);
    valid_i = 1'b1; flags_i = f; found_i = fnd; acc_i = a;
    priv_i = p; mxr_i = m; sum_i = s; vaddr_i = va;
  endtask

  task automatic expect_res(input string req, input logic ef, input logic [1:0] a,
                            input logic [VA_W-1:0] va);
    chk({req, " valid"}, 64'(valid_o), 64'(1));
    chk({req, " fault"}, 64'(fault_o), 64'(ef));
    chk({req, " cause"}, 64'(cause_o), ef ? 64'(exp_cause(a)) : 64'(0));
    chk({req, " tval"},  64'(tval_o),  ef ? 64'(va) : 64'(0));
  endtask

  // one request, result checked one cycle later
  task automatic one(input string req, input logic [4:0] f, input logic fnd,
                     input logic [1:0] a, input logic [1:0] p, input logic m,
                     input logic s, input logic ef);
    logic [VA_W-1:0] va;
    seq++;
    va = 32'h8000_0000 + 32'(seq) * 32'h0001_2345;
    @(negedge clk);
    drive(f, fnd, a, p, m, s, va);
    @(negedge clk);
    valid_i = 1'b0;
    expect_res(req, ef, a, va);
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(valid_o), 64'(0));
    chk("R1 fault", 64'(fault_o), 64'(0));
    chk("R1 cause", 64'(cause_o), 64'(0));
    chk("R1 tval",  64'(tval_o),  64'(0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post valid", 64'(valid_o), 64'(0));
    chk("R1 post fault", 64'(fault_o), 64'(0));
  endtask

  task automatic t_missing;
    one("R3 fetch", FV|FR|FW|FX, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1);
    one("R3 load",  FV|FR|FW|FX, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1);
    one("R3 store", FV|FR|FW|FX, 1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_invalid;
    one("R4 load",  FR|FW|FX, 1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1);
    one("R4 store", FR|FW|FX, 1'b1, 2'd2, 2'd3, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_perm;
    one("R5 store no W", FV|FR|FX, 1'b1, 2'd2, 2'd3, 1'b0, 1'b0, 1'b1);
    one("R5 store W",    FV|FR|FW, 1'b1, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0);
    one("R5 fetch no X", FV|FR|FW, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1);
    one("R5 fetch X",    FV|FX,    1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0);
    one("R5 load R",     FV|FR,    1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    one("R5 load no R",  FV|FW,    1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_mxr;
    one("R6 X only mxr0", FV|FX, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    one("R6 X only mxr1", FV|FX, 1'b1, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0);
    one("R6 W only mxr1", FV|FW, 1'b1, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1);
    one("R6 store mxr1",  FV|FX, 1'b1, 2'd2, 2'd1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_sum;
    one("R7 S sum0 load",  FV|FR|FU, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    one("R7 S sum1 load",  FV|FR|FU, 1'b1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0);
    one("R7 U sum0 load",  FV|FR|FU, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    one("R7 M sum0 load",  FV|FR|FU, 1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    one("R7 S sum0 fetch", FV|FX|FU, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1);
    one("R7 S sum0 store", FV|FW|FU, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_code3;
    one("R8 code3 as load fault", FV|FW, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1);
    one("R8 code3 as load pass",  FV|FR, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_timing;
    logic [VA_W-1:0] va_a, va_b;
    va_a = 32'h1234_5000; va_b = 32'hCAFE_0ABC;
    @(negedge clk);
    drive(FV|FR, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0, va_a);   // store faults
    @(negedge clk);
    expect_res("R2 b2b first R9", 1'b1, 2'd2, va_a);
    drive(FV|FR, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, va_b);   // load passes
    @(negedge clk);
    valid_i = 1'b0;
    vaddr_i = 32'hFFFF_FFFF;
    expect_res("R2 b2b second R10", 1'b0, 2'd1, va_b);
    @(negedge clk);
    chk("R2 idle valid", 64'(valid_o), 64'(0));
    chk("R2 idle fault", 64'(fault_o), 64'(0));
    chk("R2 idle cause", 64'(cause_o), 64'(0));
    // faulting inputs without strobe are ignored
    flags_i = 5'h00; found_i = 1'b0;
    @(negedge clk);
    chk("R2 no strobe valid", 64'(valid_o), 64'(0));
    chk("R2 no strobe fault", 64'(fault_o), 64'(0));
  endtask

  initial begin
    #1;
    t_reset();
    t_missing();
    t_invalid();
    t_perm();
    t_mxr();
    t_sum();
    t_code3();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule